// File: doc/BRIEF.md
# Byte-Register SPI Flash Command Engine

This block is a small SPI master for issuing short commands to a serial flash device. A host loads an opcode, up to three address bytes and one trailing byte into byte-wide registers. It then writes a control byte that chooses the SPI clock rate, how many response bytes to collect, and a two-bit code for the number of bytes to send. The engine drops chip select, shifts the command out most significant bit first in SPI mode 0, clocks in the response, and raises chip select again. The host polls a busy bit and then reads the collected bytes back from the register window.

Only four send lengths exist: 1, 2, 4 or 5 bytes. The address bytes are held in the register window in the reverse of the order they travel on the wire. The slow and fast SPI clocks are the system clock divided by two parameter-set ratios.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, offset 0 reads 0x00 and the response slots at offsets 5, 6 and 7 read 0x00.
- R2: A write to offset 0 whose bits [7:4] are 4 or 5, made while idle, starts a transfer; bit 7 of offset 0 reads 1 from the next cycle until the transfer ends. Any other value in bits [7:4] starts nothing.
- R3: Control bits [1:0] select the number of bytes sent: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 5. The opcode (offset 1) goes first; codes 2 and 3 then send offset 4, offset 3, offset 2; codes 1 and 3 end with the byte at offset 7.
- R4: Control bits [3:2] give a read count of 0 to 3 bytes, clocked in after the sent bytes with MOSI held low; they appear at offsets 5, 6, 7 in order of arrival, and slots beyond the count read 0x00 after the transfer.
- R5: The link runs in mode 0, most significant bit first: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising edge.
- R6: Chip select is low for the whole transfer, which carries exactly 8 x (sent + read) SCK pulses, and rises in the same cycle the busy bit clears.
- R7: Control bits [7:4] = 5 give an SCK high phase of FAST_HALF system clocks; 4 gives SLOW_HALF system clocks.
- R8: A control write made while busy is ignored, and register writes during a transfer do not change the bytes of that transfer.
- R9: Offsets 1 to 4 read back the last byte written there; a read of offset 7 returns the third response slot, not the trailing send byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The hardest situation to reach from the ports is a host write that lands in the middle of a running transfer, since the window only exists while busy is set and the effect must be shown as absence of change on the wire. The bench starts a slow five-byte command, waits a handful of cycles, then writes a new control byte and a new opcode, and afterwards compares the captured MOSI stream and pulse count with the original command. A device model behind the pins serves response bytes offset by the send length, so every combination of send code and read count is driven from a vector table.

// File: rtl/spi_cmd_pkg.sv
// Package: shared types and helpers for the SPI command engine.
// Assumes at most five bytes are sent and three received per command.
package spi_cmd_pkg;

    localparam int MAX_TX = 5;
    localparam int MAX_RX = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic       fast;
        logic [1:0] rcnt;
        logic [1:0] wcode;
    } ctrl_t;

    typedef logic [MAX_TX-1:0][7:0] tx_seq_t;

    // Number of bytes sent for a two-bit length code.
    function automatic logic [2:0] send_bytes(input logic [1:0] code);
        case (code)
            2'd0:    send_bytes = 3'd1;
            2'd1:    send_bytes = 3'd2;
            2'd2:    send_bytes = 3'd4;
            default: send_bytes = 3'd5;
        endcase
    endfunction

    // Wire-order byte sequence; entry 0 is sent first.
    function automatic tx_seq_t build_seq(input logic [1:0] code,
                                          input logic [7:0] op,
                                          input logic [7:0] a_hi,
                                          input logic [7:0] a_mid,
                                          input logic [7:0] a_lo,
                                          input logic [7:0] tail);
        tx_seq_t s;
        s = '0;
        s[0] = op;
        case (code)
            2'd1: s[1] = tail;
            2'd2: begin s[1] = a_hi; s[2] = a_mid; s[3] = a_lo; end
            2'd3: begin s[1] = a_hi; s[2] = a_mid; s[3] = a_lo; s[4] = tail; end
            default: ;
        endcase
        build_seq = s;
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
// Module: spi_clk_div
// Produces a one-cycle tick every half SCK period while a transfer runs.
// Assumes FAST_HALF and SLOW_HALF are at least 1; the count restarts
// whenever run is low so the first tick comes a full half period after start.
module spi_clk_div #(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW   = $clog2(MAXH) + 1;
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_HALF - 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_HALF - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Select the terminal count for the chosen rate.
    always_comb lim = fast ? FAST_LIM : SLOW_LIM;

    assign tick = run && (cnt == lim);

    // Half-period counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_cmd_regs.sv
// Module: spi_cmd_regs
// Byte register window: opcode, reversed address bytes, trailing byte,
// three response slots and the status read. Writes to 1..4 and 7 are
// accepted at any time; the sequencer snapshots them at start.
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       busy,
    input  logic       rx_clr,
    input  logic       rx_we,
    input  logic [1:0] rx_idx,
    input  logic [7:0] rx_byte,
    output logic [7:0] op_q,
    output logic [7:0] a_hi_q,
    output logic [7:0] a_mid_q,
    output logic [7:0] a_lo_q,
    output logic [7:0] tail_q
);
    logic [MAX_RX-1:0][7:0] rx_q;

    // Host writes into the send-side byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0; a_hi_q <= '0; a_mid_q <= '0; a_lo_q <= '0; tail_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                3'd1: op_q    <= wr_data;
                3'd2: a_lo_q  <= wr_data;
                3'd3: a_mid_q <= wr_data;
                3'd4: a_hi_q  <= wr_data;
                3'd7: tail_q  <= wr_data;
                default: ;
            endcase
        end
    end

    // Response slots: cleared at start, filled as bytes arrive.
    generate
        for (genvar i = 0; i < MAX_RX; i++) begin : g_rx
            always_ff @(posedge clk) begin
                if (!rst_n || rx_clr)                   rx_q[i] <= '0;
                else if (rx_we && (rx_idx == 2'(i)))    rx_q[i] <= rx_byte;
            end
        end
    endgenerate

    // Combinational read mux.
    always_comb begin
        case (rd_addr)
            3'd0:    rd_data = {busy, 7'd0};
            3'd1:    rd_data = op_q;
            3'd2:    rd_data = a_lo_q;
            3'd3:    rd_data = a_mid_q;
            3'd4:    rd_data = a_hi_q;
            3'd5:    rd_data = rx_q[0];
            3'd6:    rd_data = rx_q[1];
            default: rd_data = rx_q[2];
        endcase
    end
endmodule

// File: rtl/spi_shift_fsm.sv
// Module: spi_shift_fsm
// Sequences one command: lowers chip select, shifts the snapshot out
// MSB first in mode 0, samples MISO on rising SCK, hands each response
// byte to the register window, then releases chip select.
// Assumes start is only raised while idle.
module spi_shift_fsm
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  ctrl_t      ctrl,
    input  tx_seq_t    seq,
    input  logic       tick,
    input  logic       miso,
    output logic       busy,
    output logic       fast_q,
    output logic       sck,
    output logic       mosi,
    output logic       cs_n,
    output logic       rx_we,
    output logic [1:0] rx_idx,
    output logic [7:0] rx_byte
);
    eng_state_t state;
    tx_seq_t    seq_q;
    logic [7:0] sh_tx;
    logic [7:0] sh_rx;
    logic [2:0] bit_cnt;
    logic [3:0] byte_idx;
    logic [3:0] total;
    logic [2:0] wbytes;
    logic [3:0] nxt;
    logic [3:0] rdiff;
    logic       byte_end;

    assign busy     = (state != ST_IDLE);
    assign mosi     = sh_tx[7];
    assign nxt      = byte_idx + 4'd1;
    assign rdiff    = byte_idx - {1'b0, wbytes};
    assign byte_end = (state == ST_SHIFT) && tick && sck && (bit_cnt == 3'd7);

    // Response byte hand-off at the falling edge that ends a read byte.
    always_comb begin
        rx_we   = byte_end && (byte_idx >= {1'b0, wbytes});
        rx_idx  = rdiff[1:0];
        rx_byte = sh_rx;
    end

    // Transfer sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            seq_q    <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            total    <= '0;
            wbytes   <= '0;
            fast_q   <= 1'b0;
            sck      <= 1'b0;
            cs_n     <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        seq_q    <= seq;
                        sh_tx    <= seq[0];
                        wbytes   <= send_bytes(ctrl.wcode);
                        total    <= {1'b0, send_bytes(ctrl.wcode)} + {2'b00, ctrl.rcnt};
                        byte_idx <= '0;
                        bit_cnt  <= '0;
                        fast_q   <= ctrl.fast;
                        sck      <= 1'b0;
                        cs_n     <= 1'b0;
                        state    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck) begin
                            sck   <= 1'b1;
                            sh_rx <= {sh_rx[6:0], miso};
                        end else begin
                            sck <= 1'b0;
                            if (bit_cnt == 3'd7) begin
                                bit_cnt  <= '0;
                                byte_idx <= nxt;
                                seq_q    <= {8'h00, seq_q[MAX_TX-1:1]};
                                sh_tx    <= (nxt < {1'b0, wbytes}) ? seq_q[1] : 8'h00;
                                if (nxt == total) state <= ST_DONE;
                            end else begin
                                bit_cnt <= bit_cnt + 3'd1;
                                sh_tx   <= {sh_tx[6:0], 1'b0};
                            end
                        end
                    end
                end
                ST_DONE: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Module: spi_cmd_engine (top)
// Register-mapped SPI command master with coded send length (1/2/4/5
// bytes), up to three response bytes and two divided clock rates.
// Assumes a single host that polls bit 7 of offset 0 for completion.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    logic       busy;
    logic       start;
    logic       tick;
    logic       fast_q;
    logic       rx_we;
    logic [1:0] rx_idx;
    logic [7:0] rx_byte;
    logic [7:0] op_q, a_hi_q, a_mid_q, a_lo_q, tail_q;
    ctrl_t      ctrl;
    tx_seq_t    seq;

    // Decode a valid start request from a control write while idle.
    always_comb begin
        ctrl.fast  = wr_data[4];
        ctrl.rcnt  = wr_data[3:2];
        ctrl.wcode = wr_data[1:0];
        start      = wr_en && (wr_addr == 3'd0) && (wr_data[7:5] == 3'b010) && !busy;
        seq        = build_seq(ctrl.wcode, op_q, a_hi_q, a_mid_q, a_lo_q, tail_q);
    end

    spi_cmd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy),
        .rx_clr  (start),
        .rx_we   (rx_we),
        .rx_idx  (rx_idx),
        .rx_byte (rx_byte),
        .op_q    (op_q),
        .a_hi_q  (a_hi_q),
        .a_mid_q (a_mid_q),
        .a_lo_q  (a_lo_q),
        .tail_q  (tail_q)
    );

    spi_clk_div #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .fast  (fast_q),
        .tick  (tick)
    );

    spi_shift_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ctrl    (ctrl),
        .seq     (seq),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .fast_q  (fast_q),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .rx_we   (rx_we),
        .rx_idx  (rx_idx),
        .rx_byte (rx_byte)
    );
endmodule

// File: rtl/spi_cmd_checker.sv
// Module: spi_cmd_checker
// Protocol and control properties for spi_cmd_engine, attached by bind.
module spi_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       cs_n,
    input logic       sck,
    input logic       mosi
);
    p_idle_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    p_sck_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck && $past(sck)) |-> $stable(mosi));

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && wr_data[7:5] == 3'b010 && !busy) |=> busy);

    p_bad_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && wr_data[7:5] != 3'b010 && !busy) |=> !busy);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $fell(busy));
endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .cs_n    (spi_cs_n),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
);

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
    localparam int FH = 2;
    localparam int SH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       spi_sck, spi_mosi, spi_miso, spi_cs_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    spi_cmd_engine #(.FAST_HALF(FH), .SLOW_HALF(SH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // Device model: captures MOSI on rising SCK, shifts MISO on falling SCK.
    logic [63:0] stream_init = '0;
    logic [63:0] stream = '0;
    logic [63:0] cap = '0;
    int          cap_bits = 0;
    int          cs_falls = 0;
    int          hi_cycles = 0;

    assign spi_miso = stream[63];

    always @(negedge spi_cs_n) begin
        stream   = stream_init;
        cap      = '0;
        cap_bits = 0;
        cs_falls = cs_falls + 1;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        cap      = {cap[62:0], spi_mosi};
        cap_bits = cap_bits + 1;
    end
    always @(negedge spi_sck) if (!spi_cs_n) stream = stream << 1;
    always @(posedge clk) if (!spi_cs_n && spi_sck) hi_cycles = hi_cycles + 1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            reg_rd(3'd0, s);
            if (!s[7]) break;
        end
    endtask

    // Vector: ctrl, op, a@4, a@3, a@2, tail, resp0, resp1, resp2
    localparam logic [71:0] VEC [6] = '{
        {8'h50, 8'h06, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 8'h5A, 8'hC3},
        {8'h5C, 8'h9F, 8'h01, 8'h02, 8'h03, 8'h04, 8'hC2, 8'h20, 8'h15},
        {8'h41, 8'h01, 8'h77, 8'h88, 8'h99, 8'h3C, 8'h11, 8'h22, 8'h33},
        {8'h46, 8'h03, 8'h12, 8'h34, 8'h56, 8'hAA, 8'h81, 8'h42, 8'h24},
        {8'h5B, 8'h02, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h0F, 8'hF0, 8'h99},
        {8'h4F, 8'hD8, 8'h9A, 8'hBC, 8'hDE, 8'h5D, 8'hFF, 8'h00, 8'h7E}
    };

    function automatic int wlen(input logic [1:0] c);
        case (c) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 5; endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  d;
        logic [63:0] exp_mosi;
        int          falls0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_rd(3'd0, d); chk("R1 status", d, 8'h00);
        chk("R1 cs_n", spi_cs_n, 1'b1);
        chk("R1 sck", spi_sck, 1'b0);
        reg_rd(3'd5, d); chk("R1 slot5", d, 8'h00);
        reg_rd(3'd7, d); chk("R1 slot7", d, 8'h00);

        // Vector loop: R2 R3 R4 R5 R6 R7 R9
        foreach (VEC[k]) begin
            logic [7:0] ctl, op, ah, am, al, tl;
            logic [7:0] rs [3];
            int w, r;
            {ctl, op, ah, am, al, tl, rs[0], rs[1], rs[2]} = VEC[k];
            w = wlen(ctl[1:0]);
            r = int'(ctl[3:2]);
            reg_wr(3'd1, op); reg_wr(3'd4, ah); reg_wr(3'd3, am);
            reg_wr(3'd2, al); reg_wr(3'd7, tl);
            reg_rd(3'd4, d); chk("R9 readback +4", d, ah);
            reg_rd(3'd2, d); chk("R9 readback +2", d, al);
            stream_init = {rs[0], rs[1], rs[2], 40'h0} >> (8 * w);
            hi_cycles = 0;
            falls0 = cs_falls;
            exp_mosi = '0;
            exp_mosi = {exp_mosi[55:0], op};
            if (ctl[1:0] >= 2'd2) begin
                exp_mosi = {exp_mosi[55:0], ah};
                exp_mosi = {exp_mosi[55:0], am};
                exp_mosi = {exp_mosi[55:0], al};
            end
            if (ctl[1:0] == 2'd1 || ctl[1:0] == 2'd3) exp_mosi = {exp_mosi[55:0], tl};
            for (int j = 0; j < r; j++) exp_mosi = {exp_mosi[55:0], 8'h00};
            reg_wr(3'd0, ctl);
            reg_rd(3'd0, d); chk("R2 busy set", d[7], 1'b1);
            wait_idle();
            chk("R6 cs released", spi_cs_n, 1'b1);
            chk("R6 one cs frame", cs_falls - falls0, 1);
            chk("R6 pulse count", cap_bits, 8 * (w + r));
            chk("R3 R5 wire bytes", cap, exp_mosi);
            chk("R7 high phase", hi_cycles, (ctl[4] ? FH : SH) * 8 * (w + r));
            for (int j = 0; j < 3; j++) begin
                reg_rd(3'(5 + j), d);
                chk("R4 R9 response slot", d, (j < r) ? rs[j] : 8'h00);
            end
        end

        // R2: invalid start nibble starts nothing
        falls0 = cs_falls;
        reg_wr(3'd0, 8'h31);
        repeat (4) @(negedge clk);
        reg_rd(3'd0, d); chk("R2 bad nibble no busy", d, 8'h00);
        chk("R2 bad nibble no cs", cs_falls - falls0, 0);

        // R8: control and register writes during a transfer are ignored
        reg_wr(3'd1, 8'hA1); reg_wr(3'd4, 8'hB2); reg_wr(3'd3, 8'hC3);
        reg_wr(3'd2, 8'hD4); reg_wr(3'd7, 8'hE5);
        stream_init = '0;
        falls0 = cs_falls;
        reg_wr(3'd0, 8'h43);
        repeat (6) @(negedge clk);
        reg_wr(3'd0, 8'h50);
        reg_wr(3'd1, 8'hEE);
        wait_idle();
        chk("R8 wire unchanged", cap, 64'h00000_0A1B2C3D4E5);
        chk("R8 pulse count", cap_bits, 40);
        chk("R8 single frame", cs_falls - falls0, 1);
        reg_rd(3'd1, d); chk("R9 late opcode write kept", d, 8'hEE);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule